// File: doc/BRIEF.md
# Two-Way Cross-Clock Mailbox

This block passes single messages between two ports that run on unrelated clocks, without going through any queue. Each direction has one 36-bit holding register. The sending port loads the register with a qualified write. The receiving port then sees an active-low "message waiting" flag in its own clock domain. When the receiver reads the register, the flag returns high. The register keeps its contents after the read. One channel carries messages from port A to port B, and an identical, mirrored channel carries them from B to A.

Port B has a configurable bus width: long (36 bits), word (18 bits) or byte (9 bits). That setting decides which bit lanes are carried in both directions. Lanes outside the active width are stored and returned as zero. The flag is set in one clock domain and cleared in the other. This uses a pair of toggle signals, and each toggle crosses into the opposite domain through a two-stage synchronizer. A sender cannot overwrite a message until its release has come back across the boundary.

Top module: `xdom_mailbox`

## Requirements
- R1: After reset both flags (`a_full_n`, `b_full_n`) are high, meaning empty, and both data outputs are zero.
- R2: A port A write (`a_cs_n`=0, `a_wr`=1, `a_sel`=1, `a_en`=1 at a rising `clk_a`) drives `b_full_n` low within four rising `clk_b` edges.
- R3: A port B read (`b_cs_n`=0, `b_wr`=0, `b_sel`=1, `b_en`=1 at a rising `clk_b`) while `b_full_n` is low returns `b_full_n` high at that edge, and `b_dout` then holds the message.
- R4: The message stays in the register after it has been read. A second read returns the same value, and `b_full_n` stays high.
- R5: A write issued while the previous message has not yet been released back to the sender is ignored. The earlier message is the one that is read.
- R6: A write attempt that lacks any one qualifier (chip select high, direction set to read, mailbox select low, or enable low) leaves the flag high.
- R7: With `b_width`=2'b01 (word), only bits 17:0 are carried. Bits 35:18 of the output read as zero.
- R8: With `b_width`=2'b10 or 2'b11 (byte), only bits 8:0 are carried. Bits 35:9 read as zero. With 2'b00 (long), all 36 bits are carried.
- R9: The mirrored channel behaves in the same way. A port B write drives `a_full_n` low, and a port A read sets it high and returns the message on `a_dout` with the lanes given by `b_width`.
- R10: Once a read has been released back to the sender, the next write is accepted and carries new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_wr | input | 1 | Port A direction, 1 write, 0 read |
| a_sel | input | 1 | Port A mailbox select |
| a_en | input | 1 | Port A enable |
| a_din | input | 36 | Port A message in |
| a_dout | output | 36 | Message from port B, loaded on an A read |
| a_full_n | output | 1 | Low while a B-to-A message waits |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| b_width | input | 2 | Port B width: 00 long, 01 word, 1x byte |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_wr | input | 1 | Port B direction, 1 write, 0 read |
| b_sel | input | 1 | Port B mailbox select |
| b_en | input | 1 | Port B enable |
| b_din | input | 36 | Port B message in |
| b_dout | output | 36 | Message from port A, loaded on a B read |
| b_full_n | output | 1 | Low while an A-to-B message waits |

## Verification
Messages are sent in both directions for every `b_width` code. The data patterns are all ones, alternating nibbles, a counting value and a walking one. All ones and the walking one expose a lane boundary placed one bit off. The alternating and counting values expose swapped or shifted lanes. Each qualifier is dropped in turn to show that a partial write request leaves the flag alone. A write sent back-to-back into a waiting message, followed by a double read, shows whether the channel overwrites the message or loses it on read.

// File: rtl/xdom_mailbox_pkg.sv
package xdom_mailbox_pkg;
  localparam int DATA_W = 36;
  localparam int WORD_W = 18;
  localparam int BYTE_W = 9;

  typedef enum logic [1:0] {
    WID_LONG = 2'b00,
    WID_WORD = 2'b01,
    WID_BYTE = 2'b10
  } width_e;

  // Ones in every lane the given width carries.
  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] w);
    logic [DATA_W-1:0] m;
    int n;
    case (w)
      WID_LONG: n = DATA_W;
      WID_WORD: n = WORD_W;
      default:  n = BYTE_W;
    endcase
    for (int i = 0; i < DATA_W; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/xdom_toggle_sync.sv
module xdom_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xdom_mbx_channel.sv
module xdom_mbx_channel
  import xdom_mailbox_pkg::*;
#(
  parameter int W      = DATA_W,
  parameter int STAGES = 2
) (
  input  logic         s_clk,
  input  logic         s_rst_n,
  input  logic         s_wr_req,
  input  logic [W-1:0] s_din,
  input  logic [W-1:0] s_mask,
  input  logic         r_clk,
  input  logic         r_rst_n,
  input  logic         r_rd_req,
  input  logic [W-1:0] r_mask,
  output logic [W-1:0] r_dout,
  output logic         r_full_n
);
  // Sender domain
  logic         s_tog;
  logic         s_ack_seen;
  logic         s_busy;
  logic         s_wr_fire;
  logic [W-1:0] s_msg;

  // Receiver domain
  logic         r_tog_seen;
  logic         r_ack_tog;
  logic         r_full;
  logic         r_rd_fire;

  assign s_busy    = s_tog ^ s_ack_seen;
  assign s_wr_fire = s_wr_req && !s_busy;

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      s_tog <= 1'b0;
      s_msg <= '0;
    end else if (s_wr_fire) begin
      s_tog <= ~s_tog;
      s_msg <= s_din & s_mask;
    end
  end

  xdom_toggle_sync #(.STAGES(STAGES)) u_set_sync (
    .clk(r_clk), .rst_n(r_rst_n), .d(s_tog), .q(r_tog_seen)
  );

  xdom_toggle_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(s_clk), .rst_n(s_rst_n), .d(r_ack_tog), .q(s_ack_seen)
  );

  assign r_full    = r_tog_seen ^ r_ack_tog;
  assign r_full_n  = ~r_full;
  assign r_rd_fire = r_rd_req;

  always_ff @(posedge r_clk or negedge r_rst_n) begin
    if (!r_rst_n) begin
      r_ack_tog <= 1'b0;
      r_dout    <= '0;
    end else if (r_rd_fire) begin
      r_dout <= s_msg & r_mask;
      if (r_full) r_ack_tog <= ~r_ack_tog;
    end
  end

  // R5: a write while busy leaves the stored message untouched
  p_busy_write_ignored_r5: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    (s_wr_req && s_busy) |=> $stable(s_msg));

  // R3: reading a waiting message releases the flag at that edge
  p_read_clears_flag_r3: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    (r_rd_fire && !r_full_n) |=> r_full_n);

  // R4: the flag never rises without a read
  p_flag_holds_r4: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    (!r_full_n && !r_rd_fire) |=> !r_full_n);

  // R7: lanes outside the active width read as zero
  p_lanes_zero_r7: assert property (@(posedge r_clk) disable iff (!r_rst_n)
    r_rd_fire |=> ((r_dout & ~$past(r_mask)) == '0));

  // R10: the sender only starts a new message when idle
  p_one_in_flight_r10: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    s_wr_fire |=> s_busy);
endmodule

// File: rtl/xdom_mailbox.sv
module xdom_mailbox
  import xdom_mailbox_pkg::*;
(
  input  logic              clk_a,
  input  logic              rst_a_n,
  input  logic              a_cs_n,
  input  logic              a_wr,
  input  logic              a_sel,
  input  logic              a_en,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  output logic              a_full_n,
  input  logic              clk_b,
  input  logic              rst_b_n,
  input  logic [1:0]        b_width,
  input  logic              b_cs_n,
  input  logic              b_wr,
  input  logic              b_sel,
  input  logic              b_en,
  input  logic [DATA_W-1:0] b_din,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_full_n
);
  logic              a_access, b_access;
  logic              a_wr_req, a_rd_req, b_wr_req, b_rd_req;
  logic [DATA_W-1:0] lanes;

  assign lanes    = lane_mask(b_width);
  assign a_access = !a_cs_n && a_sel && a_en;
  assign b_access = !b_cs_n && b_sel && b_en;
  assign a_wr_req = a_access && a_wr;
  assign a_rd_req = a_access && !a_wr;
  assign b_wr_req = b_access && b_wr;
  assign b_rd_req = b_access && !b_wr;

  // A to B
  xdom_mbx_channel #(.W(DATA_W)) u_a2b (
    .s_clk(clk_a), .s_rst_n(rst_a_n), .s_wr_req(a_wr_req),
    .s_din(a_din), .s_mask(lanes),
    .r_clk(clk_b), .r_rst_n(rst_b_n), .r_rd_req(b_rd_req),
    .r_mask(lanes), .r_dout(b_dout), .r_full_n(b_full_n)
  );

  // B to A
  xdom_mbx_channel #(.W(DATA_W)) u_b2a (
    .s_clk(clk_b), .s_rst_n(rst_b_n), .s_wr_req(b_wr_req),
    .s_din(b_din), .s_mask(lanes),
    .r_clk(clk_a), .r_rst_n(rst_a_n), .r_rd_req(a_rd_req),
    .r_mask(lanes), .r_dout(a_dout), .r_full_n(a_full_n)
  );

  // R1: right after reset both channels report empty
  p_reset_empty_r1: assert property (@(posedge clk_b)
    $rose(rst_b_n) |-> b_full_n);
endmodule

// File: tb/xdom_mailbox_test.sv
module xdom_mailbox_test;
  logic        clk_a = 0, clk_b = 0, rst_a_n = 0, rst_b_n = 0;
  logic        a_cs_n = 1, a_wr = 0, a_sel = 0, a_en = 0;
  logic        b_cs_n = 1, b_wr = 0, b_sel = 0, b_en = 0;
  logic [1:0]  b_width = 0;
  logic [35:0] a_din = 0, b_din = 0, a_dout, b_dout;
  logic        a_full_n, b_full_n;
  int total = 0, bad = 0;

  always #5 clk_a = ~clk_a;
  always #7 clk_b = ~clk_b;

  xdom_mailbox uut (.*);

  function automatic logic [35:0] exp_mask(input logic [1:0] w);
    int n = (w == 2'd0) ? 36 : (w == 2'd1) ? 18 : 9;
    return (36'd1 << n) - 36'd1;
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic a_cmd(input logic cs_n, input logic wr, input logic sel, input logic en,
                       input logic [35:0] d);
    @(negedge clk_a);
    a_cs_n = cs_n; a_wr = wr; a_sel = sel; a_en = en; a_din = d;
    @(negedge clk_a);
    a_cs_n = 1; a_sel = 0; a_en = 0;
  endtask

  task automatic b_cmd(input logic cs_n, input logic wr, input logic sel, input logic en,
                       input logic [35:0] d);
    @(negedge clk_b);
    b_cs_n = cs_n; b_wr = wr; b_sel = sel; b_en = en; b_din = d;
    @(negedge clk_b);
    b_cs_n = 1; b_sel = 0; b_en = 0;
  endtask

  task automatic wait_b_low(input string req);
    int k = 0;
    while (b_full_n && k < 4) begin @(negedge clk_b); k++; end
    chk(req, b_full_n, 1'b0);
  endtask

  task automatic wait_a_low(input string req);
    int k = 0;
    while (a_full_n && k < 6) begin @(negedge clk_a); k++; end
    chk(req, a_full_n, 1'b0);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk_b);
  endtask

  task automatic a_to_b(input logic [35:0] d, input logic [1:0] w);
    a_cmd(0, 1, 1, 1, d);
    wait_b_low("R2");
    b_cmd(0, 0, 1, 1, 0);
    chk("R3 flag", b_full_n, 1'b1);
    chk(w == 2'd0 ? "R8 long" : w == 2'd1 ? "R7 word" : "R8 byte", b_dout, d & exp_mask(w));
    settle();
  endtask

  task automatic b_to_a(input logic [35:0] d, input logic [1:0] w);
    b_cmd(0, 1, 1, 1, d);
    wait_a_low("R9 set");
    a_cmd(0, 0, 1, 1, 0);
    chk("R9 clear", a_full_n, 1'b1);
    chk("R9 data", a_dout, d & exp_mask(w));
    settle();
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [35:0] pats [4];
    pats[0] = 36'hFFFFFFFFF; pats[1] = 36'hA5A5A5A5A;
    pats[2] = 36'h123456789; pats[3] = 36'h000000000;
    repeat (3) @(negedge clk_a);
    rst_a_n = 1; rst_b_n = 1;
    @(negedge clk_b);
    chk("R1 a_full_n", a_full_n, 1'b1);
    chk("R1 b_full_n", b_full_n, 1'b1);
    chk("R1 a_dout", a_dout, 36'd0);
    chk("R1 b_dout", b_dout, 36'd0);

    // R6: each missing qualifier blocks the write
    a_cmd(1, 1, 1, 1, 36'h1); settle(); chk("R6 cs", b_full_n, 1'b1);
    a_cmd(0, 0, 1, 1, 36'h1); settle(); chk("R6 dir", b_full_n, 1'b1);
    a_cmd(0, 1, 0, 1, 36'h1); settle(); chk("R6 sel", b_full_n, 1'b1);
    a_cmd(0, 1, 1, 0, 36'h1); settle(); chk("R6 en", b_full_n, 1'b1);

    // R7 R8 R9 R10: sweep widths and patterns in both directions
    for (int w = 0; w < 4; w++) begin
      b_width = 2'(w);
      for (int p = 0; p < 5; p++) begin
        logic [35:0] d = (p < 4) ? pats[p] : (36'd1 << (w * 9 + 8));
        a_to_b(d ^ 36'(w), 2'(w));
        b_to_a(~d, 2'(w));
      end
    end

    // R5 R4: write into a waiting message, then read twice
    b_width = 2'd0;
    a_cmd(0, 1, 1, 1, 36'h111111111);
    wait_b_low("R5 set");
    a_cmd(0, 1, 1, 1, 36'h222222222);
    b_cmd(0, 0, 1, 1, 0);
    chk("R5 kept first", b_dout, 36'h111111111);
    b_cmd(0, 0, 1, 1, 0);
    chk("R4 reread", b_dout, 36'h111111111);
    chk("R4 flag high", b_full_n, 1'b1);
    settle();
    // R10: a fresh write after release is accepted
    a_to_b(36'h333333333, 2'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule